// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low Power Idle Controller

This block decides when the transmit path of an Ethernet MAC may go into Low Power Idle (LPI) and when it has to leave it. It also records LPI entry and exit events on both the transmit and the receive path. Two programmable timers set the timing. A link-stable timer counts milliseconds and must expire before LPI is allowed. A wake timer counts microseconds and holds off normal transmission after LPI ends. Both timers run from an external 1 µs tick, and the millisecond count is built from `MS_US` such ticks.

Software drives the block through two words, selected by `reg_sel`:

- **Control/status word** (`reg_sel`=0):
  - bit 0: transmit LPI entered (sticky)
  - bit 1: transmit LPI exited (sticky)
  - bit 2: receive LPI entered (sticky)
  - bit 3: receive LPI exited (sticky)
  - bit 8: transmitter is in LPI (read-only level)
  - bit 9: current level of `rx_lpi` (read-only)
  - bit 16: LPI enable
  - bit 17: automatic mode
  - bit 18: link-good flag
- **Timer word** (`reg_sel`=1):
  - bits [15:0]: wake wait in µs
  - bits [26:16]: link-stable time in ms

A read strobe on the control/status word clears all four sticky bits. The interrupt output is the OR of the sticky bits.

The transmit controller is a three-state machine:

- **Normal operation.** In ACTIVE, frames may flow and `tx_ready` is high.
- **Entering LPI (T_ENTER).** The machine moves from ACTIVE to LPI when three conditions hold together. First, an enable is set (LPI enable or automatic mode). Second, the link-good flag has been set continuously for the link-stable time. Third, the transmitter is idle and there is no transmit request.
- **Leaving LPI (T_EXIT).** The machine moves from LPI to WAKE in any of three cases: both enables are clear, the link-good flag is cleared, or a transmit request arrives while automatic mode is set.
- **Returning to normal (T_RESUME).** The machine moves from WAKE back to ACTIVE once the wake wait has elapsed.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset:
  - the state is ACTIVE, so `tx_ready`=1, `tx_lpi`=0 and `lpi_irq`=0;
  - the control/status word reads 0;
  - the timer word reads 0x03E8_0000 (link-stable time 1000 ms, wake wait 0).
- R2: The timer word holds the wake wait in bits [15:0] and the link-stable time in bits [26:16]. Bits [31:27] always read 0, so writing all ones reads back 0x07FF_FFFF.
- R3: With an enable set, the link-good flag set and `tx_idle` high, `tx_lpi` rises LS*MS_US+1 cycles after the write that sets the link-good flag (with `us_tick` held high). On entry, status bit 0 and the state bit 8 are set.
- R4: Clearing the link-good flag (bit 18) has three effects:
  - it forces an exit from LPI on the next cycle;
  - it restarts the link-stable count;
  - after the flag is set again, entry takes the full LS*MS_US+1 cycles.
- R5: Automatic mode (bit 17) affects transmit requests as follows:
  - with automatic mode set, a `tx_req` seen in LPI makes `tx_lpi` fall on the next cycle and sets status bit 1;
  - with only the LPI enable (bit 16) set, `tx_req` has no effect and `tx_lpi` stays high.
- R6: After an exit, `tx_ready` returns TW+1 cycles after the cycle in which `tx_lpi` fell, so it is low for TW+1 sampled cycles.
- R7: Writing the control word with both bit 16 and bit 17 clear while in LPI makes `tx_lpi` fall on the next cycle.
- R8: The four events set their sticky bits:
  - bit 0: transmit entry;
  - bit 1: transmit exit;
  - bit 2: rising edge of `rx_lpi`;
  - bit 3: falling edge of `rx_lpi`.

  `lpi_irq` is high exactly when any of the four bits is set.
- R9: A read strobe on the control/status word clears the sticky bits at that clock edge. An event in the same cycle as the read is not lost: its bit is set after the edge.
- R10: Writing the timer word restarts whichever timer is running. It clears the link-stable count, so entry follows LS*MS_US+1 cycles after the write. In WAKE it clears the wake count, so `tx_ready` rises TW+1 cycles after the write.
- R11: Receive LPI events follow the `rx_lpi` level. A rise sets bit 2 and a fall sets bit 3, independent of the transmit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears sticky bits when reg_sel=0) |
| reg_sel | input | 1 | 0 = control/status word, 1 = timer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| tx_idle | input | 1 | Transmitter idle, no frame pending |
| tx_req | input | 1 | New transmit request |
| rx_lpi | input | 1 | Line reports receive LPI |
| tx_lpi | output | 1 | Transmitter must signal LPI |
| tx_ready | output | 1 | Normal transmission allowed |
| lpi_irq | output | 1 | LPI event interrupt |

## Verification
Two functions can fall in the same cycle: a read that clears the sticky bits, and a new receive LPI edge. The bench provokes this in two ways. A directed case raises `rx_lpi` in the very cycle of the read strobe. A long random run toggles `rx_lpi` and issues reads on independent random draws, so many cycles combine a read with an edge. A bench function predicts the sticky word on every cycle: a read clears the old bits, and the new edge is ORed in afterwards. The word read back and `lpi_irq` are compared with that prediction each cycle.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LPI    = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_e;

    // control/status word bit positions
    localparam int unsigned STS_TX_ENT = 0;
    localparam int unsigned STS_TX_EXT = 1;
    localparam int unsigned STS_RX_ENT = 2;
    localparam int unsigned STS_RX_EXT = 3;
    localparam int unsigned STS_TX_LVL = 8;
    localparam int unsigned STS_RX_LVL = 9;
    localparam int unsigned CTL_EN     = 16;
    localparam int unsigned CTL_AUTO   = 17;
    localparam int unsigned CTL_LINK   = 18;

    // timer word field positions
    localparam int unsigned TW_LSB = 0;
    localparam int unsigned LS_LSB = 16;

    localparam int unsigned N_EVENTS = 4;

    typedef struct packed {
        logic link_good;
        logic auto_mode;
        logic en;
    } lpi_ctrl_t;

endpackage

// File: rtl/lpi_link_timer.sv
module lpi_link_timer #(
    parameter int unsigned LS_W  = 11,
    parameter int unsigned MS_US = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            link_good,
    input  logic            restart,
    input  logic [LS_W-1:0] ls_limit,
    output logic            stable
);
    localparam int unsigned PRE_W = (MS_US > 1) ? $clog2(MS_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LS_W-1:0]  ms_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (!link_good || restart) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (us_tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (ms_q < ls_limit) begin
                    ms_q <= ms_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign stable = link_good && (ms_q >= ls_limit);

    // R4: a dropped link flag leaves the count at zero
    a_r4_drop_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_good) |=> (ms_q == '0 && pre_q == '0));

    // R10: a timer write restarts the millisecond count
    a_r10_link_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (restart) |=> (ms_q == '0));

endmodule

// File: rtl/lpi_wake_timer.sv
module lpi_wake_timer #(
    parameter int unsigned TW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            start,
    input  logic            run,
    input  logic            restart,
    input  logic [TW_W-1:0] tw_limit,
    output logic            done
);
    logic [TW_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start || restart) begin
            cnt_q <= '0;
        end else if (run && us_tick && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q >= tw_limit);

    // R10: a timer write restarts the wake count
    a_r10_wake_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (restart) |=> (cnt_q == '0));

endmodule

// File: rtl/lpi_status.sv
module lpi_status #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] sticky,
    output logic         irq
);
    logic [N-1:0] sticky_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sticky_q[i] <= 1'b0;
            end else if (set[i]) begin
                sticky_q[i] <= 1'b1;
            end else if (clr) begin
                sticky_q[i] <= 1'b0;
            end
        end
    end

    assign sticky = sticky_q;
    assign irq    = |sticky_q;

    // R9: a read with no new event leaves every bit clear
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (sticky_q == '0));

    // R8/R9: an event is recorded even when it meets a read
    a_r8_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((sticky_q & $past(set)) == $past(set)));

endmodule

// File: rtl/lpi_fsm.sv
module lpi_fsm
    import eee_lpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_any,
    input  logic       auto_mode,
    input  logic       link_good,
    input  logic       link_stable,
    input  logic       tx_idle,
    input  logic       tx_req,
    input  logic       wake_done,
    output lpi_state_e state_o,
    output logic       enter_o,
    output logic       exit_o
);
    lpi_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (en_any && link_stable && tx_idle && !tx_req) begin
                    state_d = ST_LPI;                       // T_ENTER
                end
            end
            ST_LPI: begin
                if (!en_any || !link_good || (auto_mode && tx_req)) begin
                    state_d = ST_WAKE;                      // T_EXIT
                end
            end
            ST_WAKE: begin
                if (wake_done) begin
                    state_d = ST_ACTIVE;                    // T_RESUME
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    always_comb begin
        state_o = state_q;
        enter_o = (state_q == ST_ACTIVE) && (state_d == ST_LPI);
        exit_o  = (state_q == ST_LPI) && (state_d == ST_WAKE);
    end

    // R3: entry only from a stable, enabled, idle condition
    a_r3_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LPI && $past(state_q) == ST_ACTIVE)
            |-> $past(link_stable && en_any && tx_idle));

    // R7: with no enable the transmitter leaves LPI next cycle
    a_r7_disable_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LPI && !en_any) |=> (state_q == ST_WAKE));

    // R5: manual mode ignores transmit requests
    a_r5_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LPI && en_any && !auto_mode && link_good) |=> (state_q == ST_LPI));

    // R6: resume only after the wake wait reports done
    a_r6_resume_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && $past(state_q) == ST_WAKE) |-> $past(wake_done));

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int unsigned TW_W     = 16,
    parameter int unsigned LS_W     = 11,
    parameter int unsigned MS_US    = 1000,
    parameter int unsigned LS_RESET = 1000,
    parameter int unsigned TW_RESET = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        us_tick,
    input  logic        tx_idle,
    input  logic        tx_req,
    input  logic        rx_lpi,
    output logic        tx_lpi,
    output logic        tx_ready,
    output logic        lpi_irq
);
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LS_TOP = LS_LSB + LS_W;

    lpi_ctrl_t       ctrl_q;
    logic [TW_W-1:0] tw_q;
    logic [LS_W-1:0] ls_q;
    logic            rx_q;
    logic            timer_wr;
    logic            status_rd;
    logic            en_any;
    logic            link_stable;
    logic            wake_done;
    logic            tx_enter;
    logic            tx_exit;
    lpi_state_e      state;
    logic [N_EVENTS-1:0] ev_set;
    logic [N_EVENTS-1:0] sticky;
    logic            unused_wdata_bits;

    assign timer_wr  = reg_wr && reg_sel;
    assign status_rd = reg_rd && !reg_sel;
    assign en_any    = ctrl_q.en || ctrl_q.auto_mode;
    assign unused_wdata_bits = ^reg_wdata[DATA_W-1:LS_TOP];

    // register words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tw_q   <= TW_W'(TW_RESET);
            ls_q   <= LS_W'(LS_RESET);
        end else if (reg_wr) begin
            if (reg_sel) begin
                tw_q <= reg_wdata[TW_LSB +: TW_W];
                ls_q <= reg_wdata[LS_LSB +: LS_W];
            end else begin
                ctrl_q.en        <= reg_wdata[CTL_EN];
                ctrl_q.auto_mode <= reg_wdata[CTL_AUTO];
                ctrl_q.link_good <= reg_wdata[CTL_LINK];
            end
        end
    end

    // receive LPI edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
        end else begin
            rx_q <= rx_lpi;
        end
    end

    always_comb begin
        ev_set             = '0;
        ev_set[STS_TX_ENT] = tx_enter;
        ev_set[STS_TX_EXT] = tx_exit;
        ev_set[STS_RX_ENT] = rx_lpi && !rx_q;
        ev_set[STS_RX_EXT] = !rx_lpi && rx_q;
    end

    lpi_link_timer #(
        .LS_W  (LS_W),
        .MS_US (MS_US)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .link_good (ctrl_q.link_good),
        .restart   (timer_wr),
        .ls_limit  (ls_q),
        .stable    (link_stable)
    );

    lpi_wake_timer #(
        .TW_W (TW_W)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .start    (tx_exit),
        .run      (state == ST_WAKE),
        .restart  (timer_wr),
        .tw_limit (tw_q),
        .done     (wake_done)
    );

    lpi_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_any      (en_any),
        .auto_mode   (ctrl_q.auto_mode),
        .link_good   (ctrl_q.link_good),
        .link_stable (link_stable),
        .tx_idle     (tx_idle),
        .tx_req      (tx_req),
        .wake_done   (wake_done),
        .state_o     (state),
        .enter_o     (tx_enter),
        .exit_o      (tx_exit)
    );

    lpi_status #(
        .N (N_EVENTS)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (ev_set),
        .clr    (status_rd),
        .sticky (sticky),
        .irq    (lpi_irq)
    );

    assign tx_lpi   = (state == ST_LPI);
    assign tx_ready = (state == ST_ACTIVE);

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[TW_LSB +: TW_W] = tw_q;
            reg_rdata[LS_LSB +: LS_W] = ls_q;
        end else begin
            reg_rdata[N_EVENTS-1:0] = sticky;
            reg_rdata[STS_TX_LVL]   = tx_lpi;
            reg_rdata[STS_RX_LVL]   = rx_lpi;
            reg_rdata[CTL_EN]       = ctrl_q.en;
            reg_rdata[CTL_AUTO]     = ctrl_q.auto_mode;
            reg_rdata[CTL_LINK]     = ctrl_q.link_good;
        end
    end

    // R8: a receive LPI rise raises the interrupt on the next cycle
    a_r8_rx_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lpi && !rx_q) |=> lpi_irq);

    // R5: an automatic-mode request in LPI leaves LPI next cycle
    a_r5_auto_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi && ctrl_q.auto_mode && tx_req) |=> !tx_lpi);

endmodule

// File: tb/eee_lpi_ctrl_test.sv
module eee_lpi_ctrl_test;

    localparam int unsigned MS = 10;
    localparam int unsigned LS = 3;
    localparam int unsigned TW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        us_tick = 1'b1;
    logic        tx_idle = 1'b0;
    logic        tx_req = 1'b0;
    logic        rx_lpi = 1'b0;
    logic        tx_lpi;
    logic        tx_ready;
    logic        lpi_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    eee_lpi_ctrl #(.MS_US(MS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .us_tick(us_tick), .tx_idle(tx_idle), .tx_req(tx_req),
        .rx_lpi(rx_lpi), .tx_lpi(tx_lpi), .tx_ready(tx_ready),
        .lpi_irq(lpi_irq)
    );

    function automatic logic [31:0] timer_word(input int unsigned tw, input int unsigned ls);
        return ((ls & 32'h7FF) << 16) | (tw & 32'hFFFF);
    endfunction

    function automatic int entry_delay(input int unsigned ls);
        return ls * MS + 1;
    endfunction

    function automatic logic [3:0] next_sticky(input logic [3:0] cur, input logic rd,
                                               input logic prev, input logic now);
        logic [3:0] n;
        n = rd ? 4'h0 : cur;
        n[2] = n[2] | (~prev & now);
        n[3] = n[3] | (prev & ~now);
        return n;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called just after a negedge; returns just after the following negedge
    task automatic write_reg(input logic sel, input logic [31:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic read_status();
        reg_rd = 1'b1; reg_sel = 1'b0;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_rise(input bit ready_sel, input int limit, output int n);
        n = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if ((ready_sel ? tx_ready : tx_lpi) == 1'b1) begin
                n = k;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [3:0] m;
        logic rxp;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 tx_ready", tx_ready, 1);
        check("R1 tx_lpi", tx_lpi, 0);
        check("R1 irq", lpi_irq, 0);
        reg_sel = 1'b0; #1;
        check("R1 status word", reg_rdata, 32'h0);
        reg_sel = 1'b1; #1;
        check("R1 timer word", reg_rdata, timer_word(0, 1000));
        reg_sel = 1'b0;

        // R2 field layout
        write_reg(1'b1, 32'hFFFF_FFFF);
        reg_sel = 1'b1; #1;
        check("R2 reserved bits", reg_rdata, 32'h07FF_FFFF);
        reg_sel = 1'b0;
        write_reg(1'b1, timer_word(TW, LS));

        // R3 entry timing
        tx_idle = 1'b1;
        write_reg(1'b0, 32'h0007_0000);
        wait_rise(1'b0, 200, n);
        check("R3 entry delay", n, entry_delay(LS));
        #1;
        check("R3 status after entry", reg_rdata, 32'h0007_0101);
        check("R8 irq on entry", lpi_irq, 1);
        read_status();
        #1;
        check("R9 cleared by read", reg_rdata, 32'h0007_0100);
        check("R9 irq cleared", lpi_irq, 0);

        // R5 automatic exit and R6 wake wait
        tx_idle = 1'b0;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        check("R5 auto exit", tx_lpi, 0);
        check("R8 exit bit", reg_rdata[1], 1);
        wait_rise(1'b1, 50, n);
        check("R6 resume delay", n + 1, TW + 2);
        read_status();

        // R4 link drop forces exit and restarts count
        tx_idle = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 re-entered", tx_lpi, 1);
        write_reg(1'b0, 32'h0003_0000);
        @(negedge clk);
        check("R4 link drop exit", tx_lpi, 0);
        repeat (10) @(negedge clk);
        write_reg(1'b0, 32'h0007_0000);
        repeat (20) @(negedge clk);
        check("R4 no early entry", tx_lpi, 0);
        write_reg(1'b0, 32'h0003_0000);
        write_reg(1'b0, 32'h0007_0000);
        wait_rise(1'b0, 200, n);
        check("R4 restarted count", n, entry_delay(LS));

        // R10 timer write restarts link count
        tx_idle = 1'b0;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        repeat (10) @(negedge clk);
        write_reg(1'b0, 32'h0003_0000);
        write_reg(1'b0, 32'h0007_0000);
        tx_idle = 1'b1;
        repeat (19) @(negedge clk);
        write_reg(1'b1, timer_word(TW, LS));
        wait_rise(1'b0, 200, n);
        check("R10 link restart", n, entry_delay(LS));

        // R10 timer write restarts wake count
        tx_idle = 1'b0;
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        write_reg(1'b1, timer_word(TW, LS));
        wait_rise(1'b1, 50, n);
        check("R10 wake restart", n, TW + 1);

        // R5 manual mode ignores requests, R7 clearing both enables exits
        write_reg(1'b0, 32'h0005_0000);
        tx_idle = 1'b1;
        wait_rise(1'b0, 200, n);
        check("R5 manual entry", (n > 0), 1);
        tx_idle = 1'b0;
        tx_req = 1'b1;
        repeat (3) @(negedge clk);
        tx_req = 1'b0;
        check("R5 manual ignores tx_req", tx_lpi, 1);
        write_reg(1'b0, 32'h0004_0000);
        @(negedge clk);
        check("R7 forced exit", tx_lpi, 0);
        repeat (10) @(negedge clk);
        check("R7 resumed", tx_ready, 1);

        // R9 read colliding with a receive LPI rise
        read_status();
        rx_lpi = 1'b1; reg_rd = 1'b1; reg_sel = 1'b0;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        check("R9 event kept on read", reg_rdata[3:0], 4'h4);
        check("R8 irq after rx", lpi_irq, 1);
        rx_lpi = 1'b0;
        @(negedge clk);
        check("R11 rx exit bit", reg_rdata[3:0], 4'hC);

        // R9/R11 random reads against receive edges
        read_status();
        m = 4'h0;
        rxp = rx_lpi;
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 4) == 0) rx_lpi = ~rx_lpi;
            reg_rd = (($urandom % 3) == 0);
            reg_sel = 1'b0;
            @(negedge clk);
            m = next_sticky(m, reg_rd, rxp, rx_lpi);
            rxp = rx_lpi;
            check("R11 random sticky", reg_rdata[3:0], m);
            check("R8 random irq", lpi_irq, |m);
        end
        reg_rd = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule